// File: doc/BRIEF.md
# 64-bit Microsecond Time Counter with Staged Reload

The block keeps a free-running 64-bit count of microseconds. The count advances once for every cycle in which the microsecond tick input is high. Software loads a new time in two 32-bit writes: one into a staged low word and one into a staged high word. The running count takes the staged value only when a write clears the top bit of the staged high word while that bit is set. Until then, writes to either staging word leave the running time untouched. Software therefore writes the high word with its top bit at 1 and then writes it again with that bit at 0.

The live count is available as a 64-bit output and as two read-only 32-bit words. The low readback word always shows the current low half. Each read of the low word captures the matching high half, and the high readback word holds that captured value. A 64-bit read that starts with the low word stays consistent even when a carry into the upper half falls between the two accesses.

Top module: `tsc_timer64`

## Requirements
- R1: After reset the count, the captured high readback word and both staging words are zero.
- R2: With no reload, the count rises by exactly one in each cycle in which `us_tick` is 1, and it holds in every other cycle.
- R3: A write to the staged low word alone never changes the count. The count keeps following R2.
- R4: A high-word write whose bit 31 is 1 does not reload the count. A high-word write with bit 31 at 0 does not reload the count when the staged high word's bit 31 is already 0.
- R5: A high-word write with `wr_data[31]` = 0 while the staged high word's bit 31 is 1 reloads the count at that clock edge. The new count is {1'b0, wr_data[30:0], staged low word}, and a tick in that cycle is ignored.
- R6: If the low word is written in the same cycle as a reloading high write, the reload uses the low word being written.
- R7: The carry from bit 31 into bit 32 is exact. A count of 0x0000_0001_FFFF_FFFF followed by one tick gives 0x0000_0002_0000_0000.
- R8: `rd_lo_o` always equals bits 31:0 of the count. After a cycle with `rd_lo_en` = 1, `rd_hi_o` equals bits 63:32 of the count as they were in that cycle. `rd_hi_o` holds while `rd_lo_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_lo_en | input | 1 | Write strobe for the staged low word |
| wr_hi_en | input | 1 | Write strobe for the staged high word |
| wr_data | input | 32 | Write data shared by both staging words |
| rd_lo_en | input | 1 | Read strobe of the low word; captures the high half |
| time_o | output | 64 | Live count |
| rd_lo_o | output | 32 | Low readback word (live low half) |
| rd_hi_o | output | 32 | High readback word (captured high half) |

## Verification
A corrupted staging word stays hidden until the next falling-edge reload. At that edge the count jumps to a value other than the one expected, in the cycle right after the write. A false reload, for example one triggered by a low-word write or by a high write that sets bit 31, shows up on `time_o` one edge after the write. A fault in the increment or carry path shows within one tick, and a carry fault shows exactly when the low half wraps. A fault in the capture register shows on `rd_hi_o` one edge after a low-word read, or as drift while no read is made.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    // default half width of the counter
    localparam int unsigned TSC_HALF_W = 32;
endpackage

// File: rtl/tsc_stage.sv
module tsc_stage #(
    parameter int unsigned HALF_W = tsc_pkg::TSC_HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo_en,
    input  logic                wr_hi_en,
    input  logic [HALF_W-1:0]   wr_data,
    output logic                load_en,
    output logic [2*HALF_W-1:0] load_val
);
    localparam int unsigned TOP = HALF_W - 1;

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
    } stage_t;

    stage_t stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        if (wr_lo_en) stg_d.lo = wr_data;
        if (wr_hi_en) stg_d.hi = wr_data;
        // top bit of the staged high word goes 1 -> 0
        load_en  = wr_hi_en & stg_q.hi[TOP] & ~wr_data[TOP];
        load_val = {1'b0, stg_d.hi[TOP-1:0], stg_d.lo};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    AST_LO_ONLY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo_en && !wr_hi_en) |-> !load_en); // R3
    AST_MSB_SET_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_en && wr_data[TOP]) |-> !load_en); // R4
    AST_NO_STROBE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hi_en |-> !load_en); // R4
endmodule

// File: rtl/tsc_count.sv
module tsc_count #(
    parameter int unsigned CNT_W = 2 * tsc_pkg::TSC_HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en)   st_d.cnt = load_val;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(cnt_o)); // R2
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R2
    AST_LOAD_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !cnt_o[CNT_W-1]); // R5
endmodule

// File: rtl/tsc_readout.sv
module tsc_readout #(
    parameter int unsigned HALF_W = tsc_pkg::TSC_HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_lo_en,
    input  logic [2*HALF_W-1:0] cnt_i,
    output logic [HALF_W-1:0]   lo_o,
    output logic [HALF_W-1:0]   hi_o
);
    typedef struct packed {
        logic [HALF_W-1:0] shadow;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_lo_en) rd_d.shadow = cnt_i[2*HALF_W-1:HALF_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign lo_o = cnt_i[HALF_W-1:0];
    assign hi_o = rd_q.shadow;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo_en |=> $stable(hi_o)); // R8
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_en |=> (hi_o == $past(cnt_i[2*HALF_W-1:HALF_W]))); // R8
endmodule

// File: rtl/tsc_timer64.sv
module tsc_timer64 #(
    parameter int unsigned HALF_W = tsc_pkg::TSC_HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick,
    input  logic                wr_lo_en,
    input  logic                wr_hi_en,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                rd_lo_en,
    output logic [2*HALF_W-1:0] time_o,
    output logic [HALF_W-1:0]   rd_lo_o,
    output logic [HALF_W-1:0]   rd_hi_o
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic             load_en;
    logic [CNT_W-1:0] load_val;

    tsc_stage #(.HALF_W(HALF_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo_en (wr_lo_en),
        .wr_hi_en (wr_hi_en),
        .wr_data  (wr_data),
        .load_en  (load_en),
        .load_val (load_val)
    );

    tsc_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .load_en  (load_en),
        .load_val (load_val),
        .cnt_o    (time_o)
    );

    tsc_readout #(.HALF_W(HALF_W)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_lo_en (rd_lo_en),
        .cnt_i    (time_o),
        .lo_o     (rd_lo_o),
        .hi_o     (rd_hi_o)
    );

    AST_LOAD_TAKES_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_o == $past(load_val))); // R5
endmodule

// File: tb/tb_tsc_timer64.sv
module tb_tsc_timer64;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        wr_lo_en = 1'b0;
    logic        wr_hi_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_lo_en = 1'b0;
    logic [63:0] time_o;
    logic [31:0] rd_lo_o;
    logic [31:0] rd_hi_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] exp_cnt = '0;
    logic [31:0] st_lo = '0;
    logic [31:0] st_hi = '0;
    logic [31:0] exp_shadow = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tsc_timer64 dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en), .wr_data(wr_data),
        .rd_lo_en(rd_lo_en), .time_o(time_o), .rd_lo_o(rd_lo_o), .rd_hi_o(rd_hi_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic wl, input logic wh,
                        input logic [31:0] d, input logic rd, input string tag);
        logic [31:0] nlo, nhi;
        @(negedge clk);
        us_tick = tk; wr_lo_en = wl; wr_hi_en = wh; wr_data = d; rd_lo_en = rd;
        if (rd) exp_shadow = exp_cnt[63:32];
        nlo = wl ? d : st_lo;
        nhi = wh ? d : st_hi;
        if (wh && st_hi[31] && !d[31]) exp_cnt = {1'b0, nhi[30:0], nlo};
        else if (tk)                   exp_cnt = exp_cnt + 64'd1;
        st_lo = nlo; st_hi = nhi;
        @(posedge clk); #1;
        us_tick = 1'b0; wr_lo_en = 1'b0; wr_hi_en = 1'b0; rd_lo_en = 1'b0;
        check(tag, time_o, exp_cnt);
        check("R8 low", {32'd0, rd_lo_o}, {32'd0, exp_cnt[31:0]});
        check("R8 high", {32'd0, rd_hi_o}, {32'd0, exp_shadow});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 count", time_o, 64'd0);
        check("R1 high", {32'd0, rd_hi_o}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        // R2 idle then tick patterns
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 32'd0, 1'b0, "R2 idle");
        for (int i = 0; i < 24; i++) step(1'(i % 3 != 0), 1'b0, 1'b0, 32'd0, 1'b0, "R2 tick");
        // R3 low write alone
        step(1'b0, 1'b1, 1'b0, 32'hDEADBEEF, 1'b0, "R3 lo write idle");
        step(1'b1, 1'b1, 1'b0, 32'h01234567, 1'b0, "R3 lo write tick");
        step(1'b1, 1'b1, 1'b0, 32'hDEADBEEF, 1'b0, "R3 lo write tick");
        // R1 staged high zero: msb-clear write does not reload; R4
        step(1'b1, 1'b0, 1'b1, 32'h12345678, 1'b0, "R4 msb0 from 0");
        step(1'b0, 1'b0, 1'b1, 32'h80000005, 1'b0, "R4 msb1");
        step(1'b1, 1'b0, 1'b1, 32'h80000006, 1'b0, "R4 msb1 again");
        // R5 falling edge reload, tick ignored
        step(1'b1, 1'b0, 1'b1, 32'h00000005, 1'b0, "R5 reload");
        step(1'b1, 1'b0, 1'b1, 32'h00000009, 1'b0, "R4 msb0 after reload");
        // R6 same-cycle low, landing near the low carry
        step(1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, "R4 msb1 arm");
        step(1'b1, 1'b1, 1'b1, 32'h00000001, 1'b0, "R6 same cycle");
        step(1'b0, 1'b1, 1'b0, 32'hFFFFFFF0, 1'b0, "R3 stage lo");
        step(1'b0, 1'b0, 1'b1, 32'h80000001, 1'b0, "R4 arm");
        step(1'b1, 1'b0, 1'b1, 32'h00000001, 1'b1, "R5 reload carry");
        // R7 carry with reads every cycle
        for (int i = 0; i < 32; i++) step(1'b1, 1'b0, 1'b0, 32'd0, 1'b1, "R7 carry");
        check("R7 crossed", {63'd0, exp_cnt[32+1]}, 64'd1);
        // R8 shadow holds without reads
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 32'd0, 1'b0, "R8 hold");
        // sweep of reload patterns
        for (int h = 0; h < 16; h++) begin
            step(1'b0, 1'b1, 1'b0, 32'hFFFFFFFF - 32'(h), 1'b0, "R3 sweep lo");
            step(1'(h % 2), 1'b0, 1'b1, {1'b1, 31'(h * 32'h01010101)}, 1'b0, "R4 sweep arm");
            step(1'b1, 1'(h % 3 == 0), 1'b1, {1'b0, 31'(h * 32'h01010101)}, 1'b1, "R5 sweep reload");
            for (int k = 0; k < h + 2; k++) step(1'b1, 1'b0, 1'b0, 32'd0, 1'(k % 2), "R7 sweep run");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule